// File: doc/BRIEF.md
# Flash Table Pointer and Write Holding Unit

This block is the path a CPU uses to reach program flash as data. It keeps a 22-bit table pointer, made of three byte registers, and an 8-bit table latch. A table read copies the flash byte at the pointer into the latch. A table write copies the latch into one entry of a small holding buffer. Flash itself is never written from here. Each access also adjusts the pointer in one of four ways: it leaves it alone, increments it after the access, decrements it after the access, or increments it before the access.

A program controller outside this block reads the holding buffer through a separate index port. It takes the target block base and erase-row number from the pointer. When it pulses `commit`, every holding entry returns to the erased value 0xFF. Each access takes one clock edge. The latch and the pointer both update on that edge.

Top module: `tptr_unit`

## Requirements
- R1: After reset the pointer is 0x000000, the latch is 0x00 and every holding entry reads 0xFF.
- R2: A register write with `reg_sel` 00/01/10/11 loads the pointer low byte, high byte, upper byte, or latch. The upper byte keeps only 6 bits, and its bits 7:6 read 0. `reg_rdata` always shows the register chosen by `reg_sel`.
- R3: A read (`cmd_op` 01) with adjust mode 01 loads the latch with the flash byte at the pointer and then adds one to the pointer, both on one edge.
- R4: Adjust mode 10 loads or stores at the pointer and then subtracts one from it.
- R5: Adjust mode 00 performs the access at the pointer and leaves the pointer unchanged.
- R6: A write (`cmd_op` 10) with adjust mode 11 first adds one to the pointer. It then stores the latch into the holding entry at (pointer+1) modulo the buffer size. `flash_addr` presents pointer+1.
- R7: A write with mode 01 stores the latch into the entry at the pointer modulo the buffer size, then adds one to the pointer.
- R8: Pointer arithmetic carries across the three bytes and wraps within 22 bits: 0x3FFFFF+1 gives 0x000000, and 0x000000-1 gives 0x3FFFFF.
- R9: `flash_rd_en` is high only during a read. A write never reads flash and changes only the holding buffer.
- R10: `commit` sets every holding entry to 0xFF. A table write in the same cycle takes precedence for its own entry.
- R11: With `cmd_op` 00 or 11, no access takes place: the pointer, latch and buffer are unchanged, and a register write is applied.
- R12: While a read or write is active, the register write port is ignored.
- R13: `blk_base` is the pointer with its low log2(buffer size) bits cleared. `row_idx` is the pointer shifted right by 6, giving the number of the 64-byte erase row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | 00 idle, 01 table read, 10 table write, 11 idle |
| cmd_mode | input | 2 | 00 keep, 01 post-increment, 10 post-decrement, 11 pre-increment |
| reg_wr_en | input | 1 | CPU register write strobe |
| reg_sel | input | 2 | 00 low, 01 high, 10 upper, 11 latch |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register value |
| flash_addr | output | 22 | Byte address of the current access |
| flash_rd_en | output | 1 | Flash read strobe |
| flash_rdata | input | 8 | Flash byte at `flash_addr`, same cycle |
| commit | input | 1 | Controller pulse that clears the buffer to 0xFF |
| hold_rd_idx | input | 5 | Holding entry to read out |
| hold_rd_data | output | 8 | Value of the selected holding entry |
| blk_base | output | 22 | Base address of the holding block |
| row_idx | output | 16 | Erase-row number of the pointer |

## Verification
Two collisions are possible within one cycle. The first is a controller commit during a CPU table write. The bench raises `commit` on the same edge as a write to entry 7, after entry 5 was loaded earlier. It expects entry 7 to hold the new byte and entry 5 to read 0xFF. The second is a register write during a table access. It is provoked by a latch write during a read and by a low-byte write during a post-increment write. In both cases the bench expects only the access result to appear.

// File: rtl/tptr_pkg.sv
package tptr_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_NONE  = 2'b11
    } tbl_op_e;

    typedef enum logic [1:0] {
        ADJ_KEEP     = 2'b00,
        ADJ_POST_INC = 2'b01,
        ADJ_POST_DEC = 2'b10,
        ADJ_PRE_INC  = 2'b11
    } ptr_adj_e;

    typedef enum logic [1:0] {
        SEL_LOW   = 2'b00,
        SEL_HIGH  = 2'b01,
        SEL_UPPER = 2'b10,
        SEL_LATCH = 2'b11
    } reg_sel_e;
endpackage

// File: rtl/tptr_ptr_alu.sv
module tptr_ptr_alu
    import tptr_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic [PTR_W-1:0] ptr_cur,
    input  logic [1:0]       adj,
    output logic [PTR_W-1:0] acc_addr,
    output logic [PTR_W-1:0] ptr_next
);
    logic [PTR_W-1:0] ptr_plus;
    logic [PTR_W-1:0] ptr_minus;

    always_comb begin
        ptr_plus  = ptr_cur + PTR_W'(1);
        ptr_minus = ptr_cur - PTR_W'(1);
        acc_addr  = ptr_cur;
        ptr_next  = ptr_cur;
        case (ptr_adj_e'(adj))
            ADJ_POST_INC: ptr_next = ptr_plus;
            ADJ_POST_DEC: ptr_next = ptr_minus;
            ADJ_PRE_INC: begin
                acc_addr = ptr_plus;
                ptr_next = ptr_plus;
            end
            default: ptr_next = ptr_cur;
        endcase
    end
endmodule

// File: rtl/tptr_hold_bank.sv
module tptr_hold_bank #(
    parameter int HOLD_BYTES = 32,
    localparam int HOLD_AW   = $clog2(HOLD_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HOLD_AW-1:0] wr_idx,
    input  logic [7:0]         wr_data,
    input  logic               clear_all,
    input  logic [HOLD_AW-1:0] rd_idx,
    output logic [7:0]         rd_data
);
    logic [7:0] slot_q [HOLD_BYTES];

    for (genvar gi = 0; gi < HOLD_BYTES; gi++) begin : g_slot
        logic [7:0] slot_d;

        always_comb begin
            slot_d = slot_q[gi];
            if (clear_all)
                slot_d = 8'hFF;
            if (wr_en && (wr_idx == HOLD_AW'(gi)))
                slot_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[gi] <= 8'hFF;
            else        slot_q[gi] <= slot_d;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/tptr_unit.sv
module tptr_unit
    import tptr_pkg::*;
#(
    parameter int PTR_W      = 22,
    parameter int HOLD_BYTES = 32,
    parameter int ROW_BYTES  = 64,
    localparam int HOLD_AW   = $clog2(HOLD_BYTES),
    localparam int ROW_AW    = $clog2(ROW_BYTES),
    localparam int UP_W      = PTR_W - 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cmd_op,
    input  logic [1:0]         cmd_mode,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_sel,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic [PTR_W-1:0]   flash_addr,
    output logic               flash_rd_en,
    input  logic [7:0]         flash_rdata,
    input  logic               commit,
    input  logic [HOLD_AW-1:0] hold_rd_idx,
    output logic [7:0]         hold_rd_data,
    output logic [PTR_W-1:0]   blk_base,
    output logic [PTR_W-ROW_AW-1:0] row_idx
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [7:0]       latch;
    } state_t;

    state_t st_d, st_q;
    logic [PTR_W-1:0] acc_addr;
    logic [PTR_W-1:0] ptr_next;
    logic             acc_rd;
    logic             acc_wr;
    logic [PTR_W-1:0] ptr_q;
    logic [7:0]       latch_q;

    assign ptr_q   = st_q.ptr;
    assign latch_q = st_q.latch;

    tptr_ptr_alu #(.PTR_W(PTR_W)) u_alu (
        .ptr_cur  (st_q.ptr),
        .adj      (cmd_mode),
        .acc_addr (acc_addr),
        .ptr_next (ptr_next)
    );

    tptr_hold_bank #(.HOLD_BYTES(HOLD_BYTES)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_wr),
        .wr_idx    (acc_addr[HOLD_AW-1:0]),
        .wr_data   (st_q.latch),
        .clear_all (commit),
        .rd_idx    (hold_rd_idx),
        .rd_data   (hold_rd_data)
    );

    always_comb begin
        acc_rd = (tbl_op_e'(cmd_op) == OP_READ);
        acc_wr = (tbl_op_e'(cmd_op) == OP_WRITE);
        st_d   = st_q;
        if (acc_rd) begin
            st_d.latch = flash_rdata;
            st_d.ptr   = ptr_next;
        end else if (acc_wr) begin
            st_d.ptr   = ptr_next;
        end else if (reg_wr_en) begin
            case (reg_sel_e'(reg_sel))
                SEL_LOW:   st_d.ptr[7:0]         = reg_wdata;
                SEL_HIGH:  st_d.ptr[15:8]        = reg_wdata;
                SEL_UPPER: st_d.ptr[PTR_W-1:16]  = reg_wdata[UP_W-1:0];
                default:   st_d.latch            = reg_wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_LOW:   reg_rdata = st_q.ptr[7:0];
            SEL_HIGH:  reg_rdata = st_q.ptr[15:8];
            SEL_UPPER: reg_rdata = 8'(st_q.ptr[PTR_W-1:16]);
            default:   reg_rdata = st_q.latch;
        endcase
    end

    assign flash_addr  = acc_addr;
    assign flash_rd_en = acc_rd;
    assign blk_base    = {st_q.ptr[PTR_W-1:HOLD_AW], {HOLD_AW{1'b0}}};
    assign row_idx     = st_q.ptr[PTR_W-1:ROW_AW];
endmodule

// File: rtl/tptr_unit_chk.sv
module tptr_unit_chk #(
    parameter int PTR_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd_op,
    input logic [1:0]       cmd_mode,
    input logic             reg_wr_en,
    input logic [7:0]       flash_rdata,
    input logic             commit,
    input logic [7:0]       hold_rd_data,
    input logic [PTR_W-1:0] ptr,
    input logic [7:0]       latch
);
    logic access;
    assign access = (cmd_op == 2'b01) || (cmd_op == 2'b10);

    a_r3_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (access && cmd_mode == 2'b01) |=> ptr == PTR_W'($past(ptr) + PTR_W'(1)));

    a_r3_read_loads_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b01) |=> latch == $past(flash_rdata));

    a_r4_postdec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (access && cmd_mode == 2'b10) |=> ptr == PTR_W'($past(ptr) - PTR_W'(1)));

    a_r5_keep_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (access && cmd_mode == 2'b00) |=> $stable(ptr));

    a_r10_commit_erased: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmd_op != 2'b10) |=> hold_rd_data == 8'hFF);

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!access && !reg_wr_en) |=> ($stable(ptr) && $stable(latch)));

    a_r12_write_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b10 && reg_wr_en) |=> $stable(latch));
endmodule

bind tptr_unit tptr_unit_chk #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_op       (cmd_op),
    .cmd_mode     (cmd_mode),
    .reg_wr_en    (reg_wr_en),
    .flash_rdata  (flash_rdata),
    .commit       (commit),
    .hold_rd_data (hold_rd_data),
    .ptr          (ptr_q),
    .latch        (latch_q)
);

// File: tb/tptr_unit_test.sv
`timescale 1ns/1ps
module tptr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [1:0]  cmd_mode = 2'b00;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'b00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [21:0] flash_addr;
    logic        flash_rd_en;
    logic [7:0]  flash_rdata;
    logic        commit = 1'b0;
    logic [4:0]  hold_rd_idx = 5'd0;
    logic [7:0]  hold_rd_data;
    logic [21:0] blk_base;
    logic [15:0] row_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fmodel(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
    endfunction

    assign flash_rdata = fmodel(flash_addr);

    tptr_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_mode(cmd_mode),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .flash_addr(flash_addr), .flash_rd_en(flash_rd_en),
        .flash_rdata(flash_rdata), .commit(commit), .hold_rd_idx(hold_rd_idx),
        .hold_rd_data(hold_rd_data), .blk_base(blk_base), .row_idx(row_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_ptr(input logic [21:0] p);
        reg_wr(2'b10, {2'b00, p[21:16]});
        reg_wr(2'b01, p[15:8]);
        reg_wr(2'b00, p[7:0]);
    endtask

    task automatic get_reg(input logic [1:0] sel, output logic [7:0] v);
        reg_sel = sel;
        #0.1;
        v = reg_rdata;
    endtask

    task automatic get_ptr(output logic [21:0] p);
        logic [7:0] u, h, l;
        get_reg(2'b10, u); get_reg(2'b01, h); get_reg(2'b00, l);
        p = {u[5:0], h, l};
    endtask

    task automatic access(input logic [1:0] op, input logic [1:0] mode);
        @(negedge clk);
        cmd_op = op; cmd_mode = mode;
        @(negedge clk);
        cmd_op = 2'b00; cmd_mode = 2'b00;
    endtask

    task automatic hold_at(input int idx, output logic [7:0] v);
        hold_rd_idx = 5'(idx);
        #0.1;
        v = hold_rd_data;
    endtask

    task automatic t_reset;
        logic [21:0] p; logic [7:0] v;
        get_ptr(p);           chk("R1 ptr", 32'(p), 32'h0);
        get_reg(2'b11, v);    chk("R1 latch", 32'(v), 32'h0);
        hold_at(0, v);        chk("R1 hold0", 32'(v), 32'hFF);
        hold_at(31, v);       chk("R1 hold31", 32'(v), 32'hFF);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        reg_wr(2'b10, 8'hFF); get_reg(2'b10, v); chk("R2 upper masked", 32'(v), 32'h3F);
        reg_wr(2'b01, 8'h12); get_reg(2'b01, v); chk("R2 high", 32'(v), 32'h12);
        reg_wr(2'b00, 8'h34); get_reg(2'b00, v); chk("R2 low", 32'(v), 32'h34);
        reg_wr(2'b11, 8'hA5); get_reg(2'b11, v); chk("R2 latch", 32'(v), 32'hA5);
        get_reg(2'b10, v); chk("R2 upper kept", 32'(v), 32'h3F);
    endtask

    task automatic t_read_modes;
        logic [21:0] p; logic [7:0] v;
        set_ptr(22'h3F1234);
        access(2'b01, 2'b01);
        get_reg(2'b11, v); chk("R3 latch", 32'(v), 32'(fmodel(22'h3F1234)));
        get_ptr(p);        chk("R3 ptr", 32'(p), 32'h3F1235);
        access(2'b01, 2'b10);
        get_reg(2'b11, v); chk("R4 latch", 32'(v), 32'(fmodel(22'h3F1235)));
        get_ptr(p);        chk("R4 ptr", 32'(p), 32'h3F1234);
        set_ptr(22'h01ABCD);
        access(2'b01, 2'b00);
        get_reg(2'b11, v); chk("R5 latch", 32'(v), 32'(fmodel(22'h01ABCD)));
        get_ptr(p);        chk("R5 ptr", 32'(p), 32'h01ABCD);
    endtask

    task automatic t_write_modes;
        logic [21:0] p; logic [7:0] v;
        set_ptr(22'h0000FF);
        reg_wr(2'b11, 8'h77);
        @(negedge clk);
        cmd_op = 2'b10; cmd_mode = 2'b11;
        #0.1;
        chk("R6 flash_addr", 32'(flash_addr), 32'h000100);
        chk("R9 no read on write", 32'(flash_rd_en), 32'h0);
        @(negedge clk);
        cmd_op = 2'b00; cmd_mode = 2'b00;
        get_ptr(p);   chk("R6 R8 ptr carry", 32'(p), 32'h000100);
        hold_at(0, v); chk("R6 hold0", 32'(v), 32'h77);
        hold_at(31, v); chk("R6 hold31 untouched", 32'(v), 32'hFF);
        reg_wr(2'b00, 8'h01);
        reg_wr(2'b11, 8'h88);
        access(2'b10, 2'b01);
        hold_at(1, v); chk("R7 hold1", 32'(v), 32'h88);
        get_ptr(p);   chk("R7 ptr", 32'(p), 32'h000102);
        get_reg(2'b11, v); chk("R9 latch unchanged by write", 32'(v), 32'h88);
        @(negedge clk);
        cmd_op = 2'b01; cmd_mode = 2'b00;
        #0.1;
        chk("R9 read strobe", 32'(flash_rd_en), 32'h1);
        @(negedge clk);
        cmd_op = 2'b00;
    endtask

    task automatic t_wrap;
        logic [21:0] p;
        set_ptr(22'h3FFFFF);
        access(2'b01, 2'b01);
        get_ptr(p); chk("R8 wrap up", 32'(p), 32'h0);
        access(2'b01, 2'b10);
        get_ptr(p); chk("R8 wrap down", 32'(p), 32'h3FFFFF);
    endtask

    task automatic t_idle;
        logic [21:0] p; logic [7:0] v;
        set_ptr(22'h000020);
        reg_wr(2'b11, 8'h5C);
        @(negedge clk);
        cmd_op = 2'b11; cmd_mode = 2'b01;
        @(negedge clk);
        cmd_op = 2'b00; cmd_mode = 2'b00;
        get_ptr(p);        chk("R11 op11 ptr", 32'(p), 32'h000020);
        get_reg(2'b11, v); chk("R11 op11 latch", 32'(v), 32'h5C);
        hold_at(0, v);     chk("R11 op11 hold", 32'(v), 32'h77);
        @(negedge clk);
        cmd_op = 2'b11; reg_wr_en = 1'b1; reg_sel = 2'b00; reg_wdata = 8'h2D;
        @(negedge clk);
        cmd_op = 2'b00; reg_wr_en = 1'b0;
        get_ptr(p); chk("R11 reg write applies", 32'(p), 32'h00002D);
    endtask

    task automatic t_collide_regs;
        logic [21:0] p; logic [7:0] v;
        set_ptr(22'h000010);
        reg_wr(2'b11, 8'h22);
        @(negedge clk);
        cmd_op = 2'b01; cmd_mode = 2'b00;
        reg_wr_en = 1'b1; reg_sel = 2'b11; reg_wdata = 8'h99;
        @(negedge clk);
        cmd_op = 2'b00; reg_wr_en = 1'b0;
        get_reg(2'b11, v); chk("R12 read beats latch write", 32'(v), 32'(fmodel(22'h000010)));
        @(negedge clk);
        cmd_op = 2'b10; cmd_mode = 2'b01;
        reg_wr_en = 1'b1; reg_sel = 2'b00; reg_wdata = 8'h55;
        @(negedge clk);
        cmd_op = 2'b00; reg_wr_en = 1'b0;
        get_ptr(p); chk("R12 write beats low write", 32'(p), 32'h000011);
    endtask

    task automatic t_block;
        set_ptr(22'h2ABCDE);
        #0.1;
        chk("R13 blk_base", 32'(blk_base), 32'h2ABCC0);
        chk("R13 row_idx", 32'(row_idx), 32'hAAF3);
    endtask

    task automatic t_commit;
        logic [7:0] v;
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        hold_at(0, v); chk("R10 hold0 erased", 32'(v), 32'hFF);
        hold_at(1, v); chk("R10 hold1 erased", 32'(v), 32'hFF);
        set_ptr(22'h000005);
        reg_wr(2'b11, 8'h11);
        access(2'b10, 2'b00);
        hold_at(5, v); chk("R10 hold5 loaded", 32'(v), 32'h11);
        reg_wr(2'b00, 8'h07);
        reg_wr(2'b11, 8'h3C);
        @(negedge clk);
        cmd_op = 2'b10; cmd_mode = 2'b00; commit = 1'b1;
        @(negedge clk);
        cmd_op = 2'b00; commit = 1'b0;
        hold_at(7, v); chk("R10 write wins", 32'(v), 32'h3C);
        hold_at(5, v); chk("R10 other cleared", 32'(v), 32'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_read_modes();
        t_write_modes();
        t_wrap();
        t_idle();
        t_collide_regs();
        t_block();
        t_commit();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule